// File: doc/BRIEF.md
# Dual-Channel Pointer-Addressed Bus Interface

This block is the processor-facing register port of a two-channel serial controller. A host reaches it through active-low chip enable, read and write strobes, an interrupt-acknowledge line, a channel select, a data/control select and an 8-bit data path. The strobes are asynchronous to the block's clock, so they pass through a synchronizer first. An access starts on the synchronized clock edge where chip enable and exactly one strobe are first both seen low. At that edge the block latches the channel and data/control selects. Each strobe assertion produces exactly one action.

Each channel has one data register and a 16-entry control register file. The control file is reached indirectly through a single shared register pointer. A control write made while the pointer is zero writes control register 0 and loads the pointer from the low data bits. The next control access then reaches the register the pointer selects, and the pointer returns to zero. Data accesses never move the pointer. Write data is not taken when the write strobe falls. It is taken a parameterised number of clocks later, so a host whose data settles after the strobe is still served. The bidirectional bus is split into an input, an output and an output-enable. The pad cells sit outside the block.

The controller is a six-state machine:
- ST_IDLE waits for an access.
- ST_READ holds the read data.
- ST_WDLY counts down to the write-data sample point.
- ST_WWAIT waits for the write strobe to be released.
- ST_HOLD waits out an aborted cycle.
- ST_CONFLICT flags a read and a write strobe that are both low.

The transitions are:
- idle-to-read: enable and read are low, acknowledge is high.
- idle-to-write-delay: enable and write are low, acknowledge is high.
- idle-to-hold: a strobe is low while acknowledge is low.
- any-to-conflict: both strobes are low.
- write-delay-to-write-wait: the sample point is reached.
- read-complete and write-complete: the strobe rises, the state returns to idle and the internal operation is issued.
- abort-to-hold: enable rises or acknowledge falls while the strobe is still low.
- hold-release and conflict-release: both strobes are high, the state returns to idle.

Top module: `ptr_bus_if`

## Requirements
- R1: `d_oe` is 1 exactly while `ce_n` and `rd_n` are both 0, and 0 otherwise. This includes a write access and a read strobe given without chip enable.
- R2: After reset, every control and data register reads 0, the pointer is 0, `d_oe` is 0 and `proto_err` is 0.
- R3: A write with `dc_sel`=1 stores the byte in the data register of the channel given by `chan_sel` (0 or 1) and leaves the pointer unchanged.
- R4: A read with `dc_sel`=1 returns that channel's data register and leaves the pointer unchanged.
- R5: A control write (`dc_sel`=0) made while the pointer is 0 stores the byte in control register 0 of the selected channel and loads the pointer with bits [3:0] of the byte.
- R6: A control access made while the pointer is nonzero reaches control register number pointer: a write stores the byte there and a read returns it. After the access completes, the pointer is 0. A control read made while the pointer is 0 returns register 0.
- R7: The two channels have separate control files and data registers, and they share one pointer.
- R8: Write data is sampled on the rising clock edge SYNC_STAGES+1+WR_DLY edges after the write strobe falls. Bus changes made before that edge are taken, and changes made after it are ignored.
- R9: An access is aborted and has no effect on any register or on the pointer in these cases: `ce_n` rises before the strobe does, `ack_n` goes low during the strobe, or `ack_n` is low when the strobe is first seen. A write strobe that ends before the sample point is also aborted.
- R10: When `rd_n` and `wr_n` are both low with `ce_n` low, nothing is written and the pointer does not move. `proto_err` is 1 from the clock after the conflict is seen until both strobes have been high for the synchronizer delay.
- R11: A strobe held low for many cycles acts exactly once.
- R12: While a read access is in progress, `d_out` holds one stable value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| ack_n | input | 1 | Interrupt acknowledge, active low; accesses require it high |
| chan_sel | input | $clog2(N_CHAN) | Channel select, 0 or 1 by default |
| dc_sel | input | 1 | 1 selects the data register, 0 selects the control file |
| d_in | input | DW | Data bus input from the pad |
| d_out | output | DW | Read data toward the pad |
| d_oe | output | 1 | Pad output enable |
| proto_err | output | 1 | High while simultaneous read and write strobes are being held off |

## Verification
The assertions take for granted several things about the inputs. The channel and data/control selects are steady while a strobe is low, and every strobe lasts longer than the synchronizer delay plus the write sample delay. Under those conditions an operation is issued only on strobe release, and the pointer moves only on an issued control operation. The stimulus changes inputs only on falling clock edges. It holds each strobe for several clocks, and it leaves idle gaps longer than the synchronizer delay between accesses. The one exception is the late-data test, which deliberately moves the bus on the clocks just before and just after the write sample point.

// File: rtl/ptr_bus_pkg.sv
package ptr_bus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WDLY,
        ST_WWAIT,
        ST_HOLD,
        ST_CONFLICT
    } state_t;

endpackage

// File: rtl/ptr_bus_sync.sv
module ptr_bus_sync #(
    parameter int             W       = 4,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/ptr_bus_regs.sv
module ptr_bus_regs #(
    parameter int N_CHAN = 2,
    parameter int N_REG  = 16,
    parameter int DW     = 8,
    parameter int CW     = 1,
    parameter int PW     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_go,
    input  logic          op_wr,
    input  logic          op_dc,
    input  logic [CW-1:0] op_chan,
    input  logic [DW-1:0] op_data,
    input  logic [CW-1:0] rd_chan,
    input  logic          rd_dc,
    output logic [DW-1:0] rd_byte,
    output logic [PW-1:0] ptr
);

    logic [DW-1:0] rd_ctl [N_CHAN];
    logic [DW-1:0] rd_dat [N_CHAN];

    // Shared pointer: loaded by a control write at zero, cleared by any other control op.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (op_go && !op_dc) begin
            if (op_wr && ptr == '0) ptr <= op_data[PW-1:0];
            else                    ptr <= '0;
        end
    end

    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        logic [DW-1:0] ctl_q [N_REG];
        logic [DW-1:0] dat_q;
        logic          hit;

        assign hit = op_go && op_wr && (op_chan == CW'(c));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < N_REG; i++) ctl_q[i] <= '0;
                dat_q <= '0;
            end else if (hit) begin
                if (op_dc) dat_q      <= op_data;
                else       ctl_q[ptr] <= op_data;
            end
        end

        assign rd_ctl[c] = ctl_q[ptr];
        assign rd_dat[c] = dat_q;
    end

    assign rd_byte = rd_dc ? rd_dat[rd_chan] : rd_ctl[rd_chan];

endmodule

// File: rtl/ptr_bus_ctrl.sv
module ptr_bus_ctrl
    import ptr_bus_pkg::*;
#(
    parameter int DW     = 8,
    parameter int CW     = 1,
    parameter int WR_DLY = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_ce_n,
    input  logic          s_rd_n,
    input  logic          s_wr_n,
    input  logic          s_ack_n,
    input  logic [CW-1:0] s_chan,
    input  logic          s_dc,
    input  logic [DW-1:0] d_in,
    input  logic [DW-1:0] rd_byte,
    output state_t        st,
    output logic [DW-1:0] rd_q,
    output logic          op_go,
    output logic          op_wr,
    output logic          op_dc,
    output logic [CW-1:0] op_chan,
    output logic [DW-1:0] op_data,
    output logic          proto_err
);

    localparam int CNTW = (WR_DLY < 2) ? 1 : $clog2(WR_DLY);
    localparam logic [CNTW-1:0] CNT_LAST = CNTW'(WR_DLY - 1);

    state_t          nxt;
    logic [CNTW-1:0] cnt;
    logic            en, rd, wr, ack_ok;

    assign en     = !s_ce_n;
    assign rd     = !s_rd_n;
    assign wr     = !s_wr_n;
    assign ack_ok = s_ack_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (en && rd && wr)              nxt = ST_CONFLICT;
                else if (en && (rd || wr) && !ack_ok) nxt = ST_HOLD;
                else if (en && rd)               nxt = ST_READ;
                else if (en && wr)               nxt = ST_WDLY;
            end
            ST_READ: begin
                if (rd && wr)       nxt = ST_CONFLICT;
                else if (!ack_ok)   nxt = ST_HOLD;
                else if (!rd)       nxt = ST_IDLE;
                else if (!en)       nxt = ST_HOLD;
            end
            ST_WDLY: begin
                if (rd && wr)                     nxt = ST_CONFLICT;
                else if (!ack_ok || !wr || !en)   nxt = ST_HOLD;
                else if (cnt == CNT_LAST)         nxt = ST_WWAIT;
            end
            ST_WWAIT: begin
                if (rd && wr)       nxt = ST_CONFLICT;
                else if (!ack_ok)   nxt = ST_HOLD;
                else if (!wr)       nxt = ST_IDLE;
                else if (!en)       nxt = ST_HOLD;
            end
            ST_HOLD, ST_CONFLICT: begin
                if (!rd && !wr)     nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            rd_q      <= '0;
            op_go     <= 1'b0;
            op_wr     <= 1'b0;
            op_dc     <= 1'b0;
            op_chan   <= '0;
            op_data   <= '0;
            proto_err <= 1'b0;
        end else begin
            op_go     <= 1'b0;
            proto_err <= (nxt == ST_CONFLICT);
            if (st == ST_IDLE && nxt == ST_READ) begin
                rd_q    <= rd_byte;
                op_chan <= s_chan;
                op_dc   <= s_dc;
                op_wr   <= 1'b0;
            end
            if (st == ST_IDLE && nxt == ST_WDLY) begin
                cnt     <= '0;
                op_chan <= s_chan;
                op_dc   <= s_dc;
                op_wr   <= 1'b1;
            end
            if (st == ST_WDLY) cnt <= cnt + 1'b1;
            if (st == ST_WDLY && nxt == ST_WWAIT) op_data <= d_in;
            if ((st == ST_READ || st == ST_WWAIT) && nxt == ST_IDLE) op_go <= 1'b1;
        end
    end

endmodule

// File: rtl/ptr_bus_if.sv
module ptr_bus_if
    import ptr_bus_pkg::*;
#(
    parameter int N_CHAN      = 2,
    parameter int N_REG       = 16,
    parameter int DW          = 8,
    parameter int WR_DLY      = 2,
    parameter int SYNC_STAGES = 2,
    localparam int CW         = $clog2(N_CHAN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          ack_n,
    input  logic [CW-1:0] chan_sel,
    input  logic          dc_sel,
    input  logic [DW-1:0] d_in,
    output logic [DW-1:0] d_out,
    output logic          d_oe,
    output logic          proto_err
);

    localparam int PW = $clog2(N_REG);
    localparam int SW = 4 + CW + 1;
    localparam logic [SW-1:0] SYNC_RST = {4'b1111, {CW{1'b0}}, 1'b0};

    logic [SW-1:0] sync_q;
    logic          s_ce_n, s_rd_n, s_wr_n, s_ack_n, s_dc;
    logic [CW-1:0] s_chan;
    state_t        st;
    logic          op_go, op_wr, op_dc;
    logic [CW-1:0] op_chan;
    logic [DW-1:0] op_data, rd_byte, rd_q;
    logic [PW-1:0] ptr;

    ptr_bus_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ce_n, rd_n, wr_n, ack_n, chan_sel, dc_sel}),
        .q     (sync_q)
    );

    assign {s_ce_n, s_rd_n, s_wr_n, s_ack_n, s_chan, s_dc} = sync_q;

    ptr_bus_ctrl #(.DW(DW), .CW(CW), .WR_DLY(WR_DLY)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_ce_n    (s_ce_n),
        .s_rd_n    (s_rd_n),
        .s_wr_n    (s_wr_n),
        .s_ack_n   (s_ack_n),
        .s_chan    (s_chan),
        .s_dc      (s_dc),
        .d_in      (d_in),
        .rd_byte   (rd_byte),
        .st        (st),
        .rd_q      (rd_q),
        .op_go     (op_go),
        .op_wr     (op_wr),
        .op_dc     (op_dc),
        .op_chan   (op_chan),
        .op_data   (op_data),
        .proto_err (proto_err)
    );

    ptr_bus_regs #(.N_CHAN(N_CHAN), .N_REG(N_REG), .DW(DW), .CW(CW), .PW(PW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_go   (op_go),
        .op_wr   (op_wr),
        .op_dc   (op_dc),
        .op_chan (op_chan),
        .op_data (op_data),
        .rd_chan (s_chan),
        .rd_dc   (s_dc),
        .rd_byte (rd_byte),
        .ptr     (ptr)
    );

    assign d_out = rd_q;
    assign d_oe  = !ce_n && !rd_n;

endmodule

// File: rtl/ptr_bus_chk.sv
module ptr_bus_chk
    import ptr_bus_pkg::*;
#(
    parameter int DW = 8,
    parameter int PW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          s_ce_n,
    input logic          s_rd_n,
    input logic          s_wr_n,
    input logic          s_ack_n,
    input logic          proto_err,
    input logic          op_go,
    input logic          op_wr,
    input logic          op_dc,
    input logic [PW-1:0] op_lo,
    input logic [PW-1:0] ptr,
    input logic [DW-1:0] d_out,
    input state_t        st
);

    assert_conflict_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(proto_err) |-> ($past(s_rd_n) == 1'b0 && $past(s_wr_n) == 1'b0));

    assert_data_keeps_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_go && op_dc) |=> $stable(ptr));

    assert_ptr_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_go && op_wr && !op_dc && ptr == '0) |=> (ptr == $past(op_lo)));

    assert_ptr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_go && !op_dc && (ptr != '0 || !op_wr)) |=> (ptr == '0));

    assert_ptr_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_go |=> $stable(ptr));

    assert_valid_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_go |-> ($past(s_ack_n) && !$past(s_ce_n, 2)));

    assert_single_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
        op_go |=> !op_go);

    assert_read_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READ && $past(st) == ST_READ) |-> $stable(d_out));

endmodule

bind ptr_bus_if ptr_bus_chk #(.DW(DW), .PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_ce_n    (s_ce_n),
    .s_rd_n    (s_rd_n),
    .s_wr_n    (s_wr_n),
    .s_ack_n   (s_ack_n),
    .proto_err (proto_err),
    .op_go     (op_go),
    .op_wr     (op_wr),
    .op_dc     (op_dc),
    .op_lo     (op_data[PW-1:0]),
    .ptr       (ptr),
    .d_out     (d_out),
    .st        (st)
);

// File: tb/ptr_bus_if_tb.sv
module ptr_bus_if_tb;

    localparam int WR_DLY = 2;
    localparam int SYNC   = 2;
    localparam int LATE   = SYNC + WR_DLY;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, ack_n = 1'b1;
    logic [0:0] chan_sel = 1'b0;
    logic       dc_sel = 1'b0;
    logic [7:0] d_in = 8'h00;
    logic [7:0] d_out;
    logic       d_oe, proto_err;

    always #10 clk = ~clk;

    ptr_bus_if #(.WR_DLY(WR_DLY), .SYNC_STAGES(SYNC)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rd_n(rd_n), .wr_n(wr_n),
        .ack_n(ack_n), .chan_sel(chan_sel), .dc_sel(dc_sel), .d_in(d_in),
        .d_out(d_out), .d_oe(d_oe), .proto_err(proto_err)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0] m_ctl [2][16];
    logic [7:0] m_dat [2];
    logic [3:0] m_ptr;

    typedef struct { logic [7:0] exp; string tag; } item_t;
    item_t q[$];
    event  mon_ev;

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(mon_ev);
            if (q.size() == 0) begin
                check(1'b0, "scoreboard empty", 0, 1);
            end else begin
                item_t it;
                it = q.pop_front();
                check(d_out == it.exp, it.tag, d_out, it.exp);
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic void model_write(bit ch, bit dc, logic [7:0] d);
        if (dc) m_dat[ch] = d;
        else if (m_ptr == 4'd0) begin
            m_ctl[ch][0] = d;
            m_ptr = d[3:0];
        end else begin
            m_ctl[ch][m_ptr] = d;
            m_ptr = 4'd0;
        end
    endfunction

    task automatic do_write(bit ch, bit dc, logic [7:0] d, int hold = LATE + 3);
        @(negedge clk);
        chan_sel = ch; dc_sel = dc; d_in = d; ce_n = 0; wr_n = 0;
        idle(hold);
        check(d_oe == 1'b0, "R1 no drive during write", d_oe, 0);
        wr_n = 1; ce_n = 1;
        idle(6);
        model_write(ch, dc, d);
    endtask

    task automatic do_read(bit ch, bit dc, string tag);
        item_t it;
        @(negedge clk);
        chan_sel = ch; dc_sel = dc; ce_n = 0; rd_n = 0;
        idle(LATE + 2);
        it.exp = dc ? m_dat[ch] : m_ctl[ch][m_ptr];
        it.tag = tag;
        q.push_back(it);
        -> mon_ev;
        idle(2);
        check(d_oe == 1'b1, "R1 drive during read", d_oe, 1);
        it.tag = {tag, " R12 held"};
        q.push_back(it);
        -> mon_ev;
        idle(1);
        rd_n = 1; ce_n = 1;
        idle(1);
        check(d_oe == 1'b0, "R1 released after read", d_oe, 0);
        idle(5);
        if (!dc) m_ptr = 4'd0;
    endtask

    initial begin
        for (int c = 0; c < 2; c++) begin
            m_dat[c] = 8'h00;
            for (int r = 0; r < 16; r++) m_ctl[c][r] = 8'h00;
        end
        m_ptr = 4'd0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        check(d_oe == 1'b0, "R2 reset d_oe", d_oe, 0);
        check(proto_err == 1'b0, "R2 reset proto_err", proto_err, 0);
        do_read(0, 0, "R2 control reg reset");
        do_read(1, 1, "R2 data reg reset");

        // data register path
        do_write(0, 1, 8'hA5);
        do_write(1, 1, 8'h3C);
        do_read(0, 1, "R3 R7 data ch0");
        do_read(1, 1, "R4 R7 data ch1");

        // pointer load / pointed access
        do_write(0, 0, 8'h05);
        do_write(0, 0, 8'h77);
        do_read(0, 0, "R5 reg0 after pointer load");
        do_write(0, 0, 8'h05);
        do_read(0, 0, "R6 pointed read");
        do_read(0, 0, "R6 pointer back to zero");

        // data accesses leave the pointer alone
        do_write(1, 0, 8'h03);
        do_write(1, 1, 8'h11);
        do_read(0, 1, "R4 data read keeps pointer");
        do_write(1, 0, 8'h99);
        do_write(1, 0, 8'h03);
        do_read(1, 0, "R3 pointer kept across data access");

        // channel separation
        do_write(0, 0, 8'h03);
        do_read(0, 0, "R7 channel 0 reg3 separate");

        // R8: late data accepted, later change ignored
        @(negedge clk);
        chan_sel = 0; dc_sel = 1; d_in = 8'h10; ce_n = 0; wr_n = 0;
        idle(LATE);
        d_in = 8'h42;
        idle(1);
        d_in = 8'hEE;
        idle(3);
        wr_n = 1; ce_n = 1;
        idle(6);
        model_write(0, 1, 8'h42);
        do_read(0, 1, "R8 sample point data");

        // R9: chip enable rises before write strobe
        @(negedge clk);
        chan_sel = 1; dc_sel = 1; d_in = 8'h55; ce_n = 0; wr_n = 0;
        idle(LATE + 2);
        ce_n = 1;
        idle(3);
        wr_n = 1;
        idle(6);
        do_read(1, 1, "R9 enable abort");

        // R9: acknowledge low mid control write
        @(negedge clk);
        chan_sel = 0; dc_sel = 0; d_in = 8'h04; ce_n = 0; wr_n = 0;
        idle(LATE + 1);
        ack_n = 0;
        idle(3);
        wr_n = 1; ce_n = 1;
        idle(2);
        ack_n = 1;
        idle(6);
        do_read(0, 0, "R9 acknowledge abort");

        // R9: acknowledge low when strobe first seen
        @(negedge clk);
        ack_n = 0; chan_sel = 0; dc_sel = 1; d_in = 8'h66; ce_n = 0; wr_n = 0;
        idle(LATE + 2);
        ack_n = 1;
        idle(3);
        wr_n = 1; ce_n = 1;
        idle(6);
        do_read(0, 1, "R9 acknowledge low at start");

        // R9: aborted control read keeps pointer
        do_write(0, 0, 8'h06);
        @(negedge clk);
        chan_sel = 0; dc_sel = 0; ce_n = 0; rd_n = 0;
        idle(LATE + 1);
        ack_n = 0;
        idle(2);
        rd_n = 1; ce_n = 1;
        idle(2);
        ack_n = 1;
        idle(6);
        do_write(0, 0, 8'hAB);
        do_write(0, 0, 8'h06);
        do_read(0, 0, "R9 read abort kept pointer");

        // R10: simultaneous strobes
        @(negedge clk);
        chan_sel = 0; dc_sel = 0; d_in = 8'h0F; ce_n = 0; rd_n = 0; wr_n = 0;
        idle(LATE + 2);
        check(proto_err == 1'b1, "R10 conflict flagged", proto_err, 1);
        rd_n = 1; wr_n = 1; ce_n = 1;
        idle(LATE + 1);
        check(proto_err == 1'b0, "R10 conflict cleared", proto_err, 0);
        idle(3);
        do_read(0, 0, "R10 conflict had no effect");

        // R11: long strobe acts once
        do_write(0, 0, 8'h02, 40);
        do_read(0, 0, "R11 single action pointed read");
        do_read(0, 0, "R11 pointer zero after");

        // R1: read strobe without enable
        @(negedge clk);
        ce_n = 1; rd_n = 0;
        idle(LATE + 2);
        check(d_oe == 1'b0, "R1 no drive without enable", d_oe, 0);
        rd_n = 1;
        idle(4);

        done = 1;
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 0, 1);
            report();
            $finish;
        end
    end

endmodule